// File: doc/BRIEF.md
# Field-Aware Vertical Line Interrupt

This block watches the line timing of an interlaced video output and raises a one-cycle interrupt when a programmed line of the current field has been fully sent. Software uses the pulse to keep its buffer updates in step with the field or frame. The two fields of a frame each have their own target line and enable, so the pulse can be set to occur in the first field only, the second field only, both, or neither.

A field-start strobe clears the per-field line counter and latches the field identifier. Each end-of-line strobe compares the number of the line that just ended with the active field's target, then advances the counter, which stops at its maximum value. Configuration is a single 32-bit register on a plain write/read port, and reads return it at once.

Top module: `field_line_irq`

## Requirements
- R1: Register bits: bit 31 enables field 2, bits 16+LINE_W-1..16 hold the field-2 target line, bit 15 enables field 1, and bits LINE_W-1..0 hold the field-1 target line. Every other bit reads as 0, and writing it has no effect. With LINE_W=4, writing FFFFFFFFh reads back 800F800Fh.
- R2: After reset the register reads 0, so both fields are disabled with target 0, and the interrupt output is low.
- R3: The line counter is set to 0 by the field-start strobe and goes up by one on each end-of-line strobe. It saturates at 2^LINE_W-1.
- R4: On an end-of-line strobe, if the enable of the active field is 1 and the number of the line that just ended equals that field's target, the interrupt goes high in the following clock cycle.
- R5: A matching line in a field whose enable bit is 0 gives no interrupt.
- R6: The field identifier (0 = field 1, 1 = field 2) is sampled only at the field-start strobe. It picks the enable/target pair for the whole field, and changes to it during the field have no effect.
- R7: The interrupt is high for exactly one cycle, and it pulses at most once per field.
- R8: A register write in the same cycle as an end-of-line comparison takes effect only from the next comparison.
- R9: When a field-start strobe and an end-of-line strobe arrive in the same cycle, the field start wins. That end-of-line is neither compared nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| field_start_i | input | 1 | Field-start strobe, one cycle |
| line_end_i | input | 1 | End-of-line strobe, one cycle |
| field_id_i | input | 1 | Field identifier, sampled at field start |
| line_irq_o | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with LINE_W=4, so the counter saturates after 15 lines. This makes it practical to sweep every target value, every combination of the two enables and both field identifiers, and to run each field several lines past saturation. The bench also flips the field identifier in the middle of every field. Separate directed cases cover a write that coincides with a comparison, coincident strobes, and enabling a field only after its counter has saturated.

// File: rtl/fli_pkg.sv
package fli_pkg;
  localparam int REG_W      = 32;
  localparam int MAX_LINE_W = 12;
  localparam int F1_TGT_LSB = 0;
  localparam int F1_EN_BIT  = 15;
  localparam int F2_TGT_LSB = 16;
  localparam int F2_EN_BIT  = 31;
  localparam int NUM_FIELDS = 2;

  typedef logic [MAX_LINE_W-1:0] line_t;

  typedef struct packed {
    logic  en;
    line_t tgt;
  } fld_cfg_t;

  // Bits of the control register that hold state.
  function automatic logic [REG_W-1:0] writable_mask(input int line_w);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < line_w; i++) begin
      m[F1_TGT_LSB + i] = 1'b1;
      m[F2_TGT_LSB + i] = 1'b1;
    end
    m[F1_EN_BIT] = 1'b1;
    m[F2_EN_BIT] = 1'b1;
    return m;
  endfunction

  // Largest line number the counter can hold.
  function automatic line_t line_limit(input int line_w);
    return line_t'((1 << line_w) - 1);
  endfunction

  // Saturating increment.
  function automatic line_t sat_inc(input line_t cnt, input line_t lim);
    return (cnt >= lim) ? lim : line_t'(cnt + line_t'(1));
  endfunction

  // One field's match condition.
  function automatic logic line_hit(input fld_cfg_t c, input line_t cnt);
    return c.en && (c.tgt == cnt);
  endfunction

  function automatic fld_cfg_t unpack_field(input logic [REG_W-1:0] r,
                                            input int en_bit, input int lsb);
    fld_cfg_t c;
    c.en  = r[en_bit];
    c.tgt = r[lsb +: MAX_LINE_W];
    return c;
  endfunction
endpackage

// File: rtl/fli_cfg_reg.sv
module fli_cfg_reg
  import fli_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output fld_cfg_t         cfg_f1,
  output fld_cfg_t         cfg_f2
);
  localparam logic [REG_W-1:0] WMASK = writable_mask(LINE_W);

  logic [REG_W-1:0] reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  reg_q <= '0;
    else if (we) reg_q <= wdata & WMASK;
  end

  assign rdata  = reg_q;
  assign cfg_f1 = unpack_field(reg_q, F1_EN_BIT, F1_TGT_LSB);
  assign cfg_f2 = unpack_field(reg_q, F2_EN_BIT, F2_TGT_LSB);
endmodule

// File: rtl/fli_line_counter.sv
module fli_line_counter
  import fli_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fs,
  input  logic  eol,
  input  logic  fid,
  output line_t cnt,
  output logic  fld,
  output logic  eol_cmp
);
  localparam line_t LIM = line_limit(LINE_W);

  line_t cnt_q;
  logic  fld_q;

  // A field start in the same cycle masks the end-of-line.
  assign eol_cmp = eol && !fs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fld_q <= 1'b0;
    end else if (fs) begin
      cnt_q <= '0;
      fld_q <= fid;
    end else if (eol) begin
      cnt_q <= sat_inc(cnt_q, LIM);
    end
  end

  assign cnt = cnt_q;
  assign fld = fld_q;
endmodule

// File: rtl/fli_field_match.sv
module fli_field_match
  import fli_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fs,
  input  logic     eol_cmp,
  input  logic     fld,
  input  line_t    cnt,
  input  fld_cfg_t cfg_f1,
  input  fld_cfg_t cfg_f2,
  output logic     sel_en,
  output logic     hit,
  output logic     fired,
  output logic     irq
);
  fld_cfg_t               cfg_arr [NUM_FIELDS];
  logic [NUM_FIELDS-1:0]  field_hit;

  assign cfg_arr[0] = cfg_f1;
  assign cfg_arr[1] = cfg_f2;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign field_hit[g] = line_hit(cfg_arr[g], cnt);
  end

  logic fired_q;
  logic irq_q;

  assign sel_en = cfg_arr[fld].en;
  assign hit    = eol_cmp && field_hit[fld] && !fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= hit;
      if (fs)       fired_q <= 1'b0;
      else if (hit) fired_q <= 1'b1;
    end
  end

  assign fired = fired_q;
  assign irq   = irq_q;
endmodule

// File: rtl/field_line_irq.sv
module field_line_irq
  import fli_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              field_start_i,
  input  logic              line_end_i,
  input  logic              field_id_i,
  output logic              line_irq_o
);
  fld_cfg_t cfg_f1, cfg_f2;
  line_t    line_cnt;
  logic     act_fld;
  logic     eol_cmp;
  logic     sel_en;
  logic     hit;
  logic     fired;

  fli_cfg_reg #(.LINE_W(LINE_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .cfg_f1 (cfg_f1),
    .cfg_f2 (cfg_f2)
  );

  fli_line_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs      (field_start_i),
    .eol     (line_end_i),
    .fid     (field_id_i),
    .cnt     (line_cnt),
    .fld     (act_fld),
    .eol_cmp (eol_cmp)
  );

  fli_field_match u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs      (field_start_i),
    .eol_cmp (eol_cmp),
    .fld     (act_fld),
    .cnt     (line_cnt),
    .cfg_f1  (cfg_f1),
    .cfg_f2  (cfg_f2),
    .sel_en  (sel_en),
    .hit     (hit),
    .fired   (fired),
    .irq     (line_irq_o)
  );
endmodule

// File: rtl/field_line_irq_chk.sv
module field_line_irq_chk
  import fli_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fs,
  input logic        eol,
  input logic [31:0] rdata,
  input line_t       cnt,
  input logic        sel_en,
  input logic        fired,
  input logic        irq
);
  localparam logic [31:0] RSV = ~writable_mask(LINE_W);
  localparam line_t       LIM = line_limit(LINE_W);

  assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & RSV) == 32'd0);

  assert_cnt_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fs |=> (cnt == '0));

  assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eol && !fs && cnt == LIM) |=> (cnt == LIM));

  assert_irq_after_eol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(eol) && !$past(fs)));

  assert_irq_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(sel_en));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_once_per_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fired || $past(fs) || fs);
endmodule

bind field_line_irq field_line_irq_chk #(.LINE_W(LINE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .fs     (field_start_i),
  .eol    (line_end_i),
  .rdata  (cfg_rdata),
  .cnt    (line_cnt),
  .sel_en (sel_en),
  .fired  (fired),
  .irq    (line_irq_o)
);

// File: tb/field_line_irq_bench.sv
module field_line_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW  = 4;
  localparam int LIM = (1 << LW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        field_start_i = 1'b0;
  logic        line_end_i = 1'b0;
  logic        field_id_i = 1'b0;
  logic        line_irq_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  field_line_irq #(.LINE_W(LW)) u_field_line_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .field_start_i (field_start_i),
    .line_end_i    (line_end_i),
    .field_id_i    (field_id_i),
    .line_irq_o    (line_irq_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_cfg(input bit e2, input int t2, input bit e1, input int t1);
    return (32'(e2) << 31) | (32'(t2) << 16) | (32'(e1) << 15) | 32'(t1);
  endfunction

  task automatic write_cfg(input logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_field(input bit fid);
    field_start_i = 1'b1; field_id_i = fid;
    @(negedge clk);
    field_start_i = 1'b0;
  endtask

  // End-of-line strobe, optional write in the same cycle; irq sampled after.
  task automatic end_line(input bit we, input logic [31:0] d);
    line_end_i = 1'b1; cfg_we = we; cfg_wdata = d;
    @(negedge clk);
    line_end_i = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check(cfg_rdata, 32'h0, "R2 reset register");
    check(32'(line_irq_o), 0, "R2 reset irq");
    rst_n = 1'b1;
    @(negedge clk);
    start_field(1'b0);
    end_line(1'b0, '0);
    check(32'(line_irq_o), 0, "R2 disabled after reset");

    // R1: layout and reserved bits
    write_cfg(32'hFFFF_FFFF);
    @(negedge clk);
    check(cfg_rdata, 32'h800F_800F, "R1 all ones");
    write_cfg(32'h7FF0_7FF0);
    check(cfg_rdata, 32'h0, "R1 reserved only");
    write_cfg(pack_cfg(1'b1, 9, 1'b0, 6));
    check(cfg_rdata, 32'h8009_0006, "R1 field positions");

    // R4 R5 R6 R7 R3: sweep fields, enables, targets
    for (int fid = 0; fid < 2; fid++) begin
      for (int en = 0; en < 4; en++) begin
        for (int t = 0; t <= LIM; t++) begin
          bit fired_m = 1'b0;
          bit e1 = en[0];
          bit e2 = en[1];
          int t1 = t;
          int t2 = LIM - t;
          write_cfg(pack_cfg(e2, t2, e1, t1));
          start_field(fid[0]);
          field_id_i = ~fid[0];   // R6: mid-field change ignored
          for (int i = 0; i < LIM + 3; i++) begin
            int  line = (i > LIM) ? LIM : i;
            bit  act_en = fid ? e2 : e1;
            int  act_t  = fid ? t2 : t1;
            bit  exp = act_en && (line == act_t) && !fired_m;
            if (exp) fired_m = 1'b1;
            end_line(1'b0, '0);
            check(32'(line_irq_o), 32'(exp), "R4 R5 R6 R3 sweep pulse");
            @(negedge clk);
            check(32'(line_irq_o), 0, "R7 pulse width and once per field");
          end
        end
      end
    end

    // R3: enable only after saturation; count stuck at limit matches
    write_cfg(pack_cfg(1'b0, 0, 1'b0, LIM));
    start_field(1'b0);
    for (int i = 0; i < LIM + 5; i++) end_line(1'b0, '0);
    write_cfg(pack_cfg(1'b0, 0, 1'b1, LIM));
    end_line(1'b0, '0);
    check(32'(line_irq_o), 1, "R3 saturated count matches limit");

    // R8: write coinciding with comparison uses old value
    write_cfg(pack_cfg(1'b0, 0, 1'b1, 7));
    start_field(1'b0);
    end_line(1'b0, '0);
    end_line(1'b0, '0);
    end_line(1'b1, pack_cfg(1'b0, 0, 1'b1, 2));
    check(32'(line_irq_o), 0, "R8 new target not used same cycle");
    end_line(1'b0, '0);
    check(32'(line_irq_o), 0, "R8 line 3 no match");
    write_cfg(pack_cfg(1'b0, 0, 1'b1, 2));
    start_field(1'b0);
    end_line(1'b0, '0);
    end_line(1'b0, '0);
    end_line(1'b1, pack_cfg(1'b0, 0, 1'b1, 9));
    check(32'(line_irq_o), 1, "R8 old target used same cycle");

    // R9: coincident strobes, field start wins
    write_cfg(pack_cfg(1'b0, 0, 1'b1, 0));
    start_field(1'b0);
    end_line(1'b0, '0);
    check(32'(line_irq_o), 1, "R9 setup line 0");
    @(negedge clk);
    field_start_i = 1'b1; field_id_i = 1'b0; line_end_i = 1'b1;
    @(negedge clk);
    field_start_i = 1'b0; line_end_i = 1'b0;
    check(32'(line_irq_o), 0, "R9 coincident end-of-line ignored");
    end_line(1'b0, '0);
    check(32'(line_irq_o), 1, "R9 count still 0 after coincident strobes");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule